// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns an instruction's addressing fields into an effective address (EA) and fetches the operand at that address. Its inputs are a 4-bit mode code, a 2-bit indirection depth, a 16-bit address field A and a register number R. The surrounding pipeline supplies these together with the current program counter and raises `start_i` for one cycle. The block then reads a combinational register file port and a synchronous memory read port. The memory returns data one cycle after a read request. When the EA and operand are final, the block pulses `done_o`.

Some modes reach memory only through pointers: memory-indirect with one to three levels, post-indexed and pre-indexed. These run as a sequence of memory reads, one read per pointer level, followed by the operand read. The indexed-with-increment mode writes R+1 back to the register file on the cycle that `done_o` is high. All address arithmetic wraps modulo 2^16. Register 7 serves as the stack pointer for the stack-top mode.

Top module: `ea_gen`

## Requirements
- R1: Mode 0 (immediate) reports both EA and operand equal to A and issues no memory read.
- R2: Mode 3 (register) reports the operand as reg[R] and the EA as R zero-extended, and issues no memory read.
- R3: Mode 1 (direct) uses EA = A, mode 4 (register indirect) uses EA = reg[R] and mode 11 (stack top) uses EA = reg[7]. In each of these modes the operand is mem[EA], fetched with exactly one read.
- R4: Mode 5 (displacement) and mode 7 (indexed) use EA = A + reg[R]. Mode 6 (relative) uses EA = A + PC. Each sum wraps modulo 2^16, and the operand is mem[EA] with one read.
- R5: Mode 2 (indirect) with depth d from 1 to 3 reads d pointers in sequence, starting at A. The last pointer is the EA. The operand is mem[EA], giving d+1 reads in total.
- R6: Mode 9 (post-indexed) uses EA = mem[A] + reg[R]. Mode 10 (pre-indexed) uses EA = mem[A + reg[R]]. Each uses two reads including the operand.
- R7: Mode 8 (indexed with increment) computes the EA as mode 7 does. On the `done_o` cycle it writes reg[R]+1, modulo 2^16, to register R. No other mode writes the register file.
- R8: Mode codes 12 to 15 are illegal, and so is mode 2 with depth 0. An illegal request completes with `illegal_o` = 1, EA = 0 and operand = 0. It makes no memory read and no register write.
- R9: `busy_o` is high from the cycle after `start_i` is accepted through the `done_o` cycle. `done_o` lasts one cycle. `start_i` has no effect while `busy_o` is high.
- R10: If `start_i` is sampled at clock edge k and the request makes n memory reads, `done_o` is high in the cycle after edge k+1+2n. Read requests are never issued on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| mode_i | input | 4 | Addressing mode code |
| depth_i | input | 2 | Indirection depth for mode 2 |
| addr_i | input | 16 | Instruction address field A |
| reg_sel_i | input | 3 | Register number R |
| pc_i | input | 16 | Program counter |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | 16 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register write-back enable |
| rf_waddr_o | output | 3 | Register write-back index |
| rf_wdata_o | output | 16 | Register write-back data |
| mem_re_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the request |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ea_o | output | 16 | Effective address, valid with done |
| operand_o | output | 16 | Operand value, valid with done |
| illegal_o | output | 1 | Illegal mode or depth, valid with done |

## Verification
The bench targets several places where a design can go wrong:

- **Wrap-around.** Displacement and relative sums cross 0xFFFF, and an increment is applied to a register holding 0xFFFF. A design that carried a seventeenth bit would report the wrong address, or write back 0x10000 truncated in the wrong place.
- **Indirection depth.** All three indirection depths are run. An off-by-one level counter would stop one pointer early or late, which shows up as both a wrong EA and a wrong read count.
- **Pre- and post-indexing.** A design that swapped the order of indexing and dereference would fetch a different pointer.
- **Illegal requests and stray starts.** Depth 0 and the unused mode codes are sent to check that no read and no write leak out. A second start is pulsed mid-sequence; a design that accepted it would produce an extra or corrupted completion.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam logic [3:0] M_IMM  = 4'd0;
  localparam logic [3:0] M_DIR  = 4'd1;
  localparam logic [3:0] M_IND  = 4'd2;
  localparam logic [3:0] M_REG  = 4'd3;
  localparam logic [3:0] M_RIND = 4'd4;
  localparam logic [3:0] M_DISP = 4'd5;
  localparam logic [3:0] M_REL  = 4'd6;
  localparam logic [3:0] M_IDX  = 4'd7;
  localparam logic [3:0] M_IDXI = 4'd8;
  localparam logic [3:0] M_POST = 4'd9;
  localparam logic [3:0] M_PRE  = 4'd10;
  localparam logic [3:0] M_STK  = 4'd11;

  typedef struct packed {
    logic       ill;     // illegal mode or depth
    logic       direct;  // operand without memory
    logic       is_reg;  // operand from register file
    logic       use_a;
    logic       use_r;
    logic       use_pc;
    logic       use_sp;
    logic       post;    // add reg after pointer read
    logic       wb;      // auto-increment write-back
    logic [1:0] lvls;    // pointer reads before operand
  } ea_dec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_PTR, S_PWAIT, S_OPR, S_OWAIT, S_DONE
  } ea_state_e;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic [1:0] depth_i,
  output ea_dec_t    dec_o
);

  always_comb begin
    dec_o = '0;
    case (mode_i)
      M_IMM: begin
        dec_o.direct = 1'b1;
        dec_o.use_a  = 1'b1;
      end
      M_DIR:  dec_o.use_a = 1'b1;
      M_IND: begin
        dec_o.use_a = 1'b1;
        dec_o.lvls  = depth_i;
        dec_o.ill   = (depth_i == 2'd0);
      end
      M_REG: begin
        dec_o.direct = 1'b1;
        dec_o.is_reg = 1'b1;
      end
      M_RIND: dec_o.use_r = 1'b1;
      M_DISP, M_IDX: begin
        dec_o.use_a = 1'b1;
        dec_o.use_r = 1'b1;
      end
      M_REL: begin
        dec_o.use_a  = 1'b1;
        dec_o.use_pc = 1'b1;
      end
      M_IDXI: begin
        dec_o.use_a = 1'b1;
        dec_o.use_r = 1'b1;
        dec_o.wb    = 1'b1;
      end
      M_POST: begin
        dec_o.use_a = 1'b1;
        dec_o.lvls  = 2'd1;
        dec_o.post  = 1'b1;
      end
      M_PRE: begin
        dec_o.use_a = 1'b1;
        dec_o.use_r = 1'b1;
        dec_o.lvls  = 2'd1;
      end
      M_STK: begin
        dec_o.use_r  = 1'b1;
        dec_o.use_sp = 1'b1;
      end
      default: dec_o.ill = 1'b1;
    endcase
  end

endmodule

// File: rtl/ea_addr_unit.sv
module ea_addr_unit #(
  parameter int AW = 16
) (
  input  logic          use_a_i,
  input  logic          use_r_i,
  input  logic          use_pc_i,
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] r_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] sum_o
);

  logic [AW-1:0] a_term, r_term, pc_term;

  assign a_term  = use_a_i  ? a_i  : '0;
  assign r_term  = use_r_i  ? r_i  : '0;
  assign pc_term = use_pc_i ? pc_i : '0;
  // modulo 2^AW by truncation
  assign sum_o   = a_term + r_term + pc_term;

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NREG   = 8,
  parameter int SP_IDX = NREG - 1,
  localparam int RW    = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    depth_i,
  input  logic [AW-1:0] addr_i,
  input  logic [RW-1:0] reg_sel_i,
  input  logic [AW-1:0] pc_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [AW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [AW-1:0] rf_wdata_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] operand_o,
  output logic          illegal_o
);

  ea_state_e     state_q;
  logic [3:0]    mode_q;
  logic [1:0]    depth_q;
  logic [AW-1:0] a_q, pc_q, r_q, addr_q, opnd_q;
  logic [RW-1:0] sel_q;
  logic [1:0]    lvl_q;
  logic          ill_q;
  ea_dec_t       dec;
  logic [AW-1:0] sum;

  ea_decode u_dec (
    .mode_i (mode_q),
    .depth_i(depth_q),
    .dec_o  (dec)
  );

  ea_addr_unit #(.AW(AW)) u_add (
    .use_a_i (dec.use_a),
    .use_r_i (dec.use_r),
    .use_pc_i(dec.use_pc),
    .a_i     (a_q),
    .r_i     (rf_rdata_i),
    .pc_i    (pc_q),
    .sum_o   (sum)
  );

  assign rf_raddr_o = dec.use_sp ? RW'(SP_IDX) : sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= '0;
      depth_q <= '0;
      a_q     <= '0;
      pc_q    <= '0;
      r_q     <= '0;
      addr_q  <= '0;
      opnd_q  <= '0;
      sel_q   <= '0;
      lvl_q   <= '0;
      ill_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          mode_q  <= mode_i;
          depth_q <= depth_i;
          a_q     <= addr_i;
          pc_q    <= pc_i;
          sel_q   <= reg_sel_i;
          ill_q   <= 1'b0;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          r_q <= rf_rdata_i;
          if (dec.ill) begin
            ill_q   <= 1'b1;
            addr_q  <= '0;
            opnd_q  <= '0;
            state_q <= S_DONE;
          end else if (dec.direct) begin
            addr_q  <= dec.is_reg ? AW'(sel_q) : sum;
            opnd_q  <= dec.is_reg ? rf_rdata_i : a_q;
            state_q <= S_DONE;
          end else begin
            addr_q  <= sum;
            lvl_q   <= dec.lvls;
            state_q <= (dec.lvls != 2'd0) ? S_PTR : S_OPR;
          end
        end
        S_PTR: state_q <= S_PWAIT;
        S_PWAIT: begin
          if (lvl_q > 2'd1) begin
            addr_q  <= mem_rdata_i;
            lvl_q   <= lvl_q - 2'd1;
            state_q <= S_PTR;
          end else begin
            addr_q  <= mem_rdata_i + (dec.post ? r_q : '0);
            state_q <= S_OPR;
          end
        end
        S_OPR: state_q <= S_OWAIT;
        S_OWAIT: begin
          opnd_q  <= mem_rdata_i;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign mem_re_o   = (state_q == S_PTR) || (state_q == S_OPR);
  assign mem_addr_o = addr_q;
  assign ea_o       = addr_q;
  assign operand_o  = opnd_q;
  assign illegal_o  = done_o & ill_q;
  assign rf_we_o    = done_o & dec.wb & ~ill_q;
  assign rf_waddr_o = sel_q;
  assign rf_wdata_o = r_q + AW'(1);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R10
  read_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);
  // R10
  read_in_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (busy_o && !done_o));
  // R7
  wb_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> done_o);
  // R8
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (done_o && !rf_we_o && ea_o == '0 && operand_o == '0));

endmodule

// File: tb/test_ea_gen.sv
module test_ea_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  depth = '0;
  logic [15:0] addr = '0;
  logic [2:0]  sel = '0;
  logic [15:0] pc = '0;
  logic [2:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        mem_re;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        busy, done, illegal;
  logic [15:0] ea, operand;

  int checks = 0, fails = 0, issued = 0, retired = 0, reads_seen = 0, cyc = 0;

  always #10 clk = ~clk;

  ea_gen i_ea_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .depth_i(depth),
    .addr_i(addr), .reg_sel_i(sel), .pc_i(pc), .rf_raddr_o(rf_raddr),
    .rf_rdata_i(rf_rdata), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .rf_wdata_o(rf_wdata), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .ea_o(ea),
    .operand_o(operand), .illegal_o(illegal)
  );

  function automatic logic [15:0] memf(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] reg_init(int i);
    return (i == 5) ? 16'hFFFF : (16'(i) << 8) + 16'h0030;
  endfunction

  logic [15:0] regs [8];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= reg_init(i);
    end else if (rf_we) begin
      regs[rf_waddr] <= rf_wdata;
    end
  end
  assign rf_rdata = regs[rf_raddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re) mem_rdata <= memf(mem_addr);
  end

  typedef struct {
    logic [15:0] ea;
    logic [15:0] op;
    logic        ill;
    int          reads;
    int          done_cyc;
    logic        wb;
    logic [2:0]  wsel;
    logic [15:0] wval;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_re) reads_seen++;
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 extra done: actual 1 expected 0");
        end else begin
          exp_t  e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(r, "ea", 32'(ea), 32'(e.ea));
          chk(r, "operand", 32'(operand), 32'(e.op));
          chk(r, "illegal", 32'(illegal), 32'(e.ill));
          chk(r, "reads", 32'(reads_seen), 32'(e.reads));
          chk("R10", "done cycle", 32'(cyc), 32'(e.done_cyc));
          chk("R7", "rf_we", 32'(rf_we), 32'(e.wb));
          if (e.wb) begin
            chk("R7", "rf_waddr", 32'(rf_waddr), 32'(e.wsel));
            chk("R7", "rf_wdata", 32'(rf_wdata), 32'(e.wval));
          end
        end
        reads_seen = 0;
        retired++;
      end
    end
  end

  task automatic run_op(input logic [3:0] m, input logic [1:0] d, input logic [15:0] a,
                        input logic [2:0] s, input logic [15:0] p, input string req,
                        input bit poke);
    exp_t e;
    logic [15:0] rv, ptr;
    @(negedge clk);
    rv = regs[s];
    e.ill = 1'b0; e.wb = 1'b0; e.wsel = s; e.wval = rv + 16'd1;
    e.reads = 1; e.op = '0; e.ea = '0;
    case (m)
      4'd0: begin e.ea = a; e.op = a; e.reads = 0; end
      4'd1: e.ea = a;
      4'd2: begin
        if (d == 2'd0) e.ill = 1'b1;
        else begin
          ptr = a;
          for (int k = 0; k < int'(d); k++) ptr = memf(ptr);
          e.ea = ptr; e.reads = int'(d) + 1;
        end
      end
      4'd3: begin e.ea = 16'(s); e.op = rv; e.reads = 0; end
      4'd4: e.ea = rv;
      4'd5, 4'd7: e.ea = a + rv;
      4'd6: e.ea = a + p;
      4'd8: begin e.ea = a + rv; e.wb = 1'b1; end
      4'd9: begin e.ea = memf(a) + rv; e.reads = 2; end
      4'd10: begin e.ea = memf(a + rv); e.reads = 2; end
      4'd11: e.ea = regs[7];
      default: e.ill = 1'b1;
    endcase
    if (e.ill) begin e.ea = '0; e.op = '0; e.reads = 0; end
    else if (e.reads > 0) e.op = memf(e.ea);
    e.done_cyc = cyc + 2 + 2 * e.reads;
    exp_q.push_back(e);
    req_q.push_back(req);
    issued++;
    start = 1'b1; mode = m; depth = d; addr = a; sel = s; pc = p;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      chk("R9", "busy mid-op", 32'(busy), 32'd1);
      start = 1'b1; mode = 4'd0; addr = 16'h1111; sel = 3'd1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (retired == issued);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset busy", 32'(busy), 32'd0);
    chk("R9", "reset done", 32'(done), 32'd0);
    chk("R10", "reset mem_re", 32'(mem_re), 32'd0);
    chk("R7", "reset rf_we", 32'(rf_we), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(4'd0,  2'd0, 16'hBEEF, 3'd1, 16'h0000, "R1", 1'b0);
    run_op(4'd3,  2'd0, 16'h0000, 3'd3, 16'h0000, "R2", 1'b0);
    run_op(4'd1,  2'd0, 16'h1234, 3'd0, 16'h0000, "R3", 1'b0);
    run_op(4'd4,  2'd0, 16'h0000, 3'd4, 16'h0000, "R3", 1'b0);
    run_op(4'd11, 2'd0, 16'h0000, 3'd2, 16'h0000, "R3", 1'b0);
    run_op(4'd5,  2'd0, 16'hFFF0, 3'd2, 16'h0000, "R4", 1'b0);
    run_op(4'd6,  2'd0, 16'h0005, 3'd0, 16'hFFFE, "R4", 1'b0);
    run_op(4'd7,  2'd0, 16'h2000, 3'd6, 16'h0000, "R4", 1'b0);
    run_op(4'd2,  2'd1, 16'h4321, 3'd0, 16'h0000, "R5", 1'b0);
    run_op(4'd2,  2'd2, 16'h0A0B, 3'd0, 16'h0000, "R5", 1'b0);
    // R9 start pulsed while busy must be ignored
    run_op(4'd2,  2'd3, 16'h7777, 3'd0, 16'h0000, "R5", 1'b1);
    run_op(4'd9,  2'd0, 16'h0100, 3'd3, 16'h0000, "R6", 1'b0);
    run_op(4'd10, 2'd0, 16'h0100, 3'd3, 16'h0000, "R6", 1'b0);
    run_op(4'd8,  2'd0, 16'h0010, 3'd5, 16'h0000, "R7", 1'b0);
    run_op(4'd3,  2'd0, 16'h0000, 3'd5, 16'h0000, "R7", 1'b0);
    run_op(4'd8,  2'd0, 16'h0010, 3'd2, 16'h0000, "R7", 1'b0);
    run_op(4'd4,  2'd0, 16'h0000, 3'd2, 16'h0000, "R7", 1'b0);
    run_op(4'd2,  2'd0, 16'h5555, 3'd1, 16'h0000, "R8", 1'b0);
    run_op(4'd12, 2'd1, 16'h5555, 3'd1, 16'h0000, "R8", 1'b0);
    run_op(4'd15, 2'd3, 16'hAAAA, 3'd2, 16'h0000, "R8", 1'b0);
    run_op(4'd3,  2'd0, 16'h0000, 3'd1, 16'h0000, "R8", 1'b0);

    repeat (3) @(negedge clk);
    chk("R9", "idle busy", 32'(busy), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule